// File: doc/BRIEF.md
# Tier-Reserved Read Request Queue

This block sits at one input of an interconnect switch and holds read requests on their way downstream. Each arriving request carries a 4-bit priority value. Two programmable cut points sort that value into one of three tiers: low, medium or high. The queue capacity is split by tier. A programmable count of entries can only be taken by high requests. A second programmable count can be taken by high or medium requests. Low requests compete only for the shared entries that are left. This stops a flood of background reads from taking the entries that latency-sensitive traffic needs.

Admission is checked against the total fill level at the start of each cycle. The limit for that check depends on the tier of the request being offered, so backpressure applies only to the tier that has run out of room. Accepted requests leave in arrival order on a valid/ready output. Each entry keeps the tier it was given on arrival. Settings that contradict each other are clamped, and an error output flags them.

A small control state machine follows the fill level. It has three states:
- `ST_EMPTY`: nothing queued.
- `ST_ACTIVE`: partly filled.
- `ST_FULL`: every entry taken.

It has four transitions:
- T_FIRST: `ST_EMPTY` to `ST_ACTIVE` on the first accepted request. With a depth of one this goes straight to `ST_FULL`.
- T_FILL: `ST_ACTIVE` to `ST_FULL` when the last free entry is taken.
- T_RELEASE: `ST_FULL` to `ST_ACTIVE` when an entry is dequeued.
- T_DRAIN: `ST_ACTIVE` to `ST_EMPTY` when the last entry leaves.

Top module: `rdq_tiered`

## Requirements
- R1: Classification into tiers works as follows. A request whose priority is at or above `cfg_thr_hi` is high (tier code 2). Otherwise, a priority at or below `cfg_thr_lo` is low (tier code 0). Anything else is medium (tier code 1). The code fixed at acceptance is presented on `out_tier` when the entry reaches the head.
- R2: A low request is accepted only while `fill_level` < DEPTH − Rh − Rm. Here Rh and Rm are the clamped reserve counts from R8.
- R3: A medium request is accepted only while `fill_level` < DEPTH − Rh.
- R4: A high request is accepted only while `fill_level` < DEPTH.
- R5: `in_ready` depends only on the tier of the request currently presented and on the fill level. It does not depend on `in_valid`. A blocked tier does not block a different tier offered in the next cycle.
- R6: Requests leave in acceptance order. `out_valid` is high exactly when the queue is non-empty. While `out_valid` is high and `out_ready` is low, the head fields hold steady.
- R7: `fill_level` rises by one for each accepted request and falls by one for each dequeue, in the cycle after the handshake. A push and a pop in the same cycle leave it unchanged.
- R8: `cfg_err` is high when `cfg_thr_lo` ≥ `cfg_thr_hi` or when `cfg_rsv_hi` + `cfg_rsv_mid` > DEPTH. The reserves are clamped as Rh = min(`cfg_rsv_hi`, DEPTH) and Rm = min(`cfg_rsv_mid`, DEPTH − Rh).
- R9: After reset the queue is empty: `out_valid` = 0 and `fill_level` = 0.
- R10: With `cfg_thr_lo` ≥ `cfg_thr_hi`, no request is classified medium. The R1 order still applies, so the high test comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thr_lo | input | QOS_W | Highest priority still counted low |
| cfg_thr_hi | input | QOS_W | Lowest priority counted high |
| cfg_rsv_hi | input | CNT_W | Entries reserved for high requests only |
| cfg_rsv_mid | input | CNT_W | Further entries reserved for high or medium requests |
| cfg_err | output | 1 | Inconsistent threshold or reserve setting |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Offered request's tier can be admitted |
| in_qos | input | QOS_W | Priority of offered request |
| in_addr | input | ADDR_W | Address of offered request |
| out_valid | output | 1 | Head entry available |
| out_ready | input | 1 | Downstream takes head entry |
| out_qos | output | QOS_W | Priority of head entry |
| out_addr | output | ADDR_W | Address of head entry |
| out_tier | output | 2 | Tier code of head entry |
| fill_level | output | CNT_W | Entries currently held |

## Verification
The bench builds the queue with DEPTH = 8, QOS_W = 4 and ADDR_W = 12. At this depth the three admission limits are separate, reachable fill levels. With reserves of 2 and 2, the low limit is 4, the medium limit is 6 and the high limit is 8. A short directed fill can therefore stand at each limit and offer every tier there. Randomised traffic then runs under several settings: valid ones, zero reserves, reserves that over-subscribe the eight entries, and swapped thresholds. These runs exercise the clamping, the error flag and the collapse to two tiers. A behavioural queue in the bench checks the outputs on every clock.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
    typedef enum logic [1:0] {
        TIER_LOW  = 2'd0,
        TIER_MID  = 2'd1,
        TIER_HIGH = 2'd2
    } tier_e;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FULL   = 2'd2
    } fill_e;
endpackage

// File: rtl/rdq_classify.sv
module rdq_classify
    import rdq_pkg::*;
#(
    parameter int QOS_W = 4
) (
    input  logic [QOS_W-1:0] qos,
    input  logic [QOS_W-1:0] thr_lo,
    input  logic [QOS_W-1:0] thr_hi,
    output tier_e            tier,
    output logic             thr_bad
);
    always_comb begin
        thr_bad = (thr_lo >= thr_hi);
        // high test first, so inverted thresholds leave only two tiers
        if (qos >= thr_hi)
            tier = TIER_HIGH;
        else if (qos <= thr_lo)
            tier = TIER_LOW;
        else
            tier = TIER_MID;
    end
endmodule

// File: rtl/rdq_admit.sv
module rdq_admit
    import rdq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  tier_e            tier,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] rsv_hi,
    input  logic [CNT_W-1:0] rsv_mid,
    input  logic             thr_bad,
    output logic             grant,
    output logic             cfg_err
);
    localparam int EW = CNT_W + 1;
    localparam logic [EW-1:0] CAP = EW'(DEPTH);

    logic [EW-1:0] rh_eff, rm_eff, room, lim_low, lim_mid, rsv_sum, fill_x;

    always_comb begin
        fill_x  = {1'b0, fill};
        rh_eff  = ({1'b0, rsv_hi} > CAP) ? CAP : {1'b0, rsv_hi};
        room    = CAP - rh_eff;
        rm_eff  = ({1'b0, rsv_mid} > room) ? room : {1'b0, rsv_mid};
        lim_mid = room;
        lim_low = room - rm_eff;
        rsv_sum = {1'b0, rsv_hi} + {1'b0, rsv_mid};
        cfg_err = thr_bad | (rsv_sum > CAP);
        unique case (tier)
            TIER_LOW:  grant = (fill_x < lim_low);
            TIER_MID:  grant = (fill_x < lim_mid);
            TIER_HIGH: grant = (fill_x < CAP);
            default:   grant = 1'b0;
        endcase
    end

    // limits must be ordered: low <= mid <= full capacity
    always_comb begin
        a_r8_limit_order: assert (lim_low <= lim_mid && lim_mid <= CAP)
            else $error("a_r8_limit_order: reserve clamp produced disordered limits");
    end
endmodule

// File: rtl/rdq_ctrl.sv
module rdq_ctrl
    import rdq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic             not_empty,
    output logic [CNT_W-1:0] count,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    fill_e            state, state_nxt;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = count + CNT_W'(push) - CNT_W'(pop);
    end

    // next state: T_FIRST, T_FILL, T_RELEASE, T_DRAIN
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY:  if (push) state_nxt = (cnt_nxt == CAP) ? ST_FULL : ST_ACTIVE;
            ST_ACTIVE: begin
                if (cnt_nxt == '0)      state_nxt = ST_EMPTY;
                else if (cnt_nxt == CAP) state_nxt = ST_FULL;
            end
            ST_FULL:   if (pop) state_nxt = (cnt_nxt == '0) ? ST_EMPTY : ST_ACTIVE;
            default:   state_nxt = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_EMPTY;
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            state <= state_nxt;
            count <= cnt_nxt;
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // outputs
    always_comb begin
        not_empty = (state != ST_EMPTY);
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP)
        else $error("a_r7_no_overflow");

    a_r6_empty_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) == (count == '0))
        else $error("a_r6_empty_state");

    a_r4_full_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) == (count == CAP))
        else $error("a_r4_full_state");

    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FULL |-> !push)
        else $error("a_r7_no_push_full");
endmodule

// File: rtl/rdq_store.sv
module rdq_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 18,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] wptr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTR_W-1:0] rptr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wptr] <= wdata;
    end

    always_comb begin
        rdata = mem[rptr];
    end
endmodule

// File: rtl/rdq_tiered.sv
module rdq_tiered
    import rdq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int QOS_W  = 4,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QOS_W-1:0]  cfg_thr_lo,
    input  logic [QOS_W-1:0]  cfg_thr_hi,
    input  logic [CNT_W-1:0]  cfg_rsv_hi,
    input  logic [CNT_W-1:0]  cfg_rsv_mid,
    output logic              cfg_err,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [QOS_W-1:0]  in_qos,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [QOS_W-1:0]  out_qos,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        out_tier,
    output logic [CNT_W-1:0]  fill_level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int ENT_W = 2 + QOS_W + ADDR_W;

    tier_e            in_tier;
    logic             thr_bad, grant, push, pop, not_empty;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [ENT_W-1:0] head;

    rdq_classify #(.QOS_W(QOS_W)) u_class (
        .qos(in_qos), .thr_lo(cfg_thr_lo), .thr_hi(cfg_thr_hi),
        .tier(in_tier), .thr_bad(thr_bad)
    );

    rdq_admit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_admit (
        .tier(in_tier), .fill(fill_level), .rsv_hi(cfg_rsv_hi),
        .rsv_mid(cfg_rsv_mid), .thr_bad(thr_bad),
        .grant(grant), .cfg_err(cfg_err)
    );

    rdq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .not_empty(not_empty), .count(fill_level),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    rdq_store #(.DEPTH(DEPTH), .WIDTH(ENT_W), .PTR_W(PTR_W)) u_store (
        .clk(clk), .we(push), .wptr(wr_ptr),
        .wdata({in_tier, in_qos, in_addr}),
        .rptr(rd_ptr), .rdata(head)
    );

    always_comb begin
        in_ready  = grant;
        push      = in_valid & grant;
        out_valid = not_empty;
        pop       = not_empty & out_ready;
        out_tier  = head[ENT_W-1 -: 2];
        out_qos   = head[ADDR_W +: QOS_W];
        out_addr  = head[ADDR_W-1:0];
    end

    a_r2_low_room: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_err && push && in_tier == TIER_LOW) |->
            (int'(fill_level) + int'(cfg_rsv_hi) + int'(cfg_rsv_mid) < DEPTH))
        else $error("a_r2_low_room");

    a_r3_mid_room: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_err && push && in_tier == TIER_MID) |->
            (int'(fill_level) + int'(cfg_rsv_hi) < DEPTH))
        else $error("a_r3_mid_room");

    a_r4_high_open: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tier == TIER_HIGH && int'(fill_level) < DEPTH) |-> in_ready)
        else $error("a_r4_high_open");

    a_r6_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                      && $stable(out_qos) && $stable(out_tier)))
        else $error("a_r6_head_hold");

    a_r1_tier_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tier != 2'd3)
        else $error("a_r1_tier_code");
endmodule

// File: tb/rdq_tiered_bench.sv
`timescale 1ns/1ps
module rdq_tiered_bench;
    localparam int DEPTH  = 8;
    localparam int QOS_W  = 4;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct {
        int tier;
        int qos;
        int addr;
    } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [QOS_W-1:0]  cfg_thr_lo = 4'd4, cfg_thr_hi = 4'd10;
    logic [CNT_W-1:0]  cfg_rsv_hi = 2, cfg_rsv_mid = 2;
    logic              cfg_err, in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
    logic [QOS_W-1:0]  in_qos = '0, out_qos;
    logic [ADDR_W-1:0] in_addr = '0, out_addr;
    logic [1:0]        out_tier;
    logic [CNT_W-1:0]  fill_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    ent_t q[$];

    always #2.5 clk = ~clk;

    rdq_tiered #(.DEPTH(DEPTH), .QOS_W(QOS_W), .ADDR_W(ADDR_W)) u_rdq_tiered (
        .clk(clk), .rst_n(rst_n),
        .cfg_thr_lo(cfg_thr_lo), .cfg_thr_hi(cfg_thr_hi),
        .cfg_rsv_hi(cfg_rsv_hi), .cfg_rsv_mid(cfg_rsv_mid), .cfg_err(cfg_err),
        .in_valid(in_valid), .in_ready(in_ready), .in_qos(in_qos), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_qos(out_qos),
        .out_addr(out_addr), .out_tier(out_tier), .fill_level(fill_level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // tier per R1 / R10
    function automatic int tier_of(input int qv, input int lo, input int hi);
        if (qv >= hi) return 2;
        if (qv <= lo) return 0;
        return 1;
    endfunction

    // one cycle: drive at falling edge, compare, then advance the model
    task automatic step(input bit v, input int qv, input int av, input bit ordy);
        int fill, t, rh, rm, lim;
        bit exp_rdy, exp_err, pop, push;
        string tag;
        ent_t e;
        @(negedge clk);
        in_valid  = v;
        in_qos    = QOS_W'(qv);
        in_addr   = ADDR_W'(av);
        out_ready = ordy;
        #1;
        fill = q.size();
        t    = tier_of(qv, int'(cfg_thr_lo), int'(cfg_thr_hi));
        rh   = (int'(cfg_rsv_hi) > DEPTH) ? DEPTH : int'(cfg_rsv_hi);
        rm   = (int'(cfg_rsv_mid) > DEPTH - rh) ? DEPTH - rh : int'(cfg_rsv_mid);
        lim  = (t == 0) ? DEPTH - rh - rm : (t == 1) ? DEPTH - rh : DEPTH;
        exp_rdy = (fill < lim);
        tag = (t == 0) ? "R2 R5" : (t == 1) ? "R3 R5" : "R4 R5";
        chk(in_ready == exp_rdy, tag, int'(in_ready), int'(exp_rdy));
        exp_err = (cfg_thr_lo >= cfg_thr_hi) ||
                  (int'(cfg_rsv_hi) + int'(cfg_rsv_mid) > DEPTH);
        chk(cfg_err == exp_err, "R8", int'(cfg_err), int'(exp_err));
        chk(int'(fill_level) == fill, "R7", int'(fill_level), fill);
        chk(out_valid == (fill > 0), "R6 valid", int'(out_valid), int'(fill > 0));
        if (fill > 0) begin
            e = q[0];
            chk(int'(out_addr) == e.addr, "R6 order", int'(out_addr), e.addr);
            chk(int'(out_qos) == e.qos, "R6 qos", int'(out_qos), e.qos);
            chk(int'(out_tier) == e.tier, "R1 R10 tier", int'(out_tier), e.tier);
        end
        pop  = ordy && (fill > 0);
        push = v && exp_rdy;
        if (pop) void'(q.pop_front());
        if (push) begin
            e.tier = t;
            e.qos  = qv;
            e.addr = av;
            q.push_back(e);
        end
    endtask

    task automatic set_cfg(input int lo, input int hi, input int rh, input int rm);
        @(negedge clk);
        cfg_thr_lo  = QOS_W'(lo);
        cfg_thr_hi  = QOS_W'(hi);
        cfg_rsv_hi  = CNT_W'(rh);
        cfg_rsv_mid = CNT_W'(rm);
    endtask

    initial begin
        int addr = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: empty after reset
        chk(out_valid == 1'b0, "R9 valid", int'(out_valid), 0);
        chk(fill_level == '0, "R9 fill", int'(fill_level), 0);

        // directed: limits 4 / 6 / 8 with thresholds 4 and 10
        for (int k = 0; k < 5; k++) begin step(1, 2, addr, 0); addr++; end   // R2: 5th low refused
        step(1, 7, addr, 0); addr++;                                        // R5: medium still taken
        step(1, 3, addr, 0); addr++;                                        // R2: low still refused
        step(1, 7, addr, 0); addr++;                                        // R3: fill 5 -> 6
        step(1, 8, addr, 0); addr++;                                        // R3: medium refused at 6
        step(1, 12, addr, 0); addr++;                                       // R4: high at 6
        step(1, 15, addr, 0); addr++;                                       // R4: high at 7
        step(1, 15, addr, 0); addr++;                                       // R4: refused at 8
        step(0, 0, 0, 0);                                                   // R6: head held
        step(1, 11, addr, 1); addr++;                                       // R7: pop at full, push refused
        for (int k = 0; k < 10; k++) step(0, 0, 0, 1);                      // drain

        // randomised phases under several settings
        for (int ph = 0; ph < 6; ph++) begin
            case (ph)
                0: set_cfg(4, 10, 2, 2);
                1: set_cfg(1, 14, 0, 0);
                2: set_cfg(6, 9, 3, 1);
                3: set_cfg(5, 11, 6, 5);   // R8 over-subscribed reserves
                4: set_cfg(9, 5, 1, 2);    // R10 swapped thresholds
                default: set_cfg(7, 7, 15, 15);
            endcase
            for (int k = 0; k < 600; k++) begin
                step(($urandom % 4) != 0, int'($urandom % 16), addr,
                     ($urandom % 3) == 0);
                addr = (addr + 1) % 4096;
            end
            for (int k = 0; k < 10; k++) step(0, 0, 0, 1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule